// File: doc/BRIEF.md
# Interrupt Context Shadow Unit

This block sits beside the execution pipeline of a small 8-bit controller with 12-bit instruction words and provides single-level interrupt context handling. When an interrupt request is pending and no handler is running, the unit raises a one-cycle take strobe. In that same cycle it copies the live program counter, working register, status byte and file select register into shadow registers. The core uses the strobe to flush its pipeline and jump to the vector address, which the unit drives on its own output.

While a handler runs, the unit watches the decoded instruction stream for the two return-from-interrupt opcodes. One return puts the saved context back. The other does the same and also asks the core to add the working register to the real-time counter, which lets a periodic handler cancel its own entry latency. Each return takes two cycles, or three when the core runs in turbo mode. The restore strobe comes in the last of these cycles, together with the restored values. The watchdog time-out and power-down status flags are never restored: they pass through from the live status byte, so the sleep and watchdog-clear logic keeps control of them. Further requests are held pending until the return completes.

Top module: `irq_ctx_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `take_o`, `restore_o`, `rtcc_wr_o` and `in_isr_o` are all 0.
- R2: A request seen on `irq_req_i` at a clock edge makes the unit pending. In any cycle where it is pending and `in_isr_o` is 0, `take_o` is 1 for exactly that cycle and `vec_pc_o` equals the vector address, which defaults to 0. At that edge the unit captures `pc_i`, `w_i`, `status_i` and `fsr_i`, and `in_isr_o` is 1 from the next cycle.
- R3: While `in_isr_o` is 1, `take_o` stays 0 and requests stay pending. A pending request is taken in the first cycle after the restore strobe.
- R4: When `in_isr_o` is 1 and no return is already in progress, `instr_valid_i` high with `instr_i` equal to 0x00E (plain return) or 0x00F (return that adds W) starts a return. `restore_o` is 1 for one cycle: the cycle after the decode cycle when `turbo_i` was 0 in the decode cycle, or the second cycle after it when `turbo_i` was 1.
- R5: While `restore_o` is 1, `rst_pc_o`, `rst_w_o` and `rst_fsr_o` equal the values captured at the take.
- R6: While `restore_o` is 1, `rst_status_o` bits 7..5 and 2..0 equal the captured status byte. Bit 4 (time-out) and bit 3 (power-down) equal the live `status_i` bits in that same cycle.
- R7: For the 0x00F return, `rtcc_wr_o` is 1 in the restore cycle, and `rtcc_wdata_o` is `rtcc_i` of that cycle plus the `w_i` of the decode cycle, modulo 256. For the 0x00E return, `rtcc_wr_o` stays 0.
- R8: A return opcode has no effect in any of these cases: `in_isr_o` is 0, a return is already in progress, or `instr_valid_i` is 0. Any other opcode, for example 0x003 (sleep) or 0x004 (watchdog clear), also has no effect.
- R9: `in_isr_o` stays 1 from the cycle after the take up to and including the restore cycle. It is 0 in the cycle after the restore cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request, sampled each edge |
| turbo_i | input | 1 | Turbo mode, selects the three-cycle return |
| instr_valid_i | input | 1 | Decoded instruction is valid this cycle |
| instr_i | input | 12 | Decoded instruction word |
| pc_i | input | 11 | Live program counter |
| w_i | input | 8 | Live working register |
| status_i | input | 8 | Live status byte |
| fsr_i | input | 8 | Live file select register |
| rtcc_i | input | 8 | Live real-time counter |
| take_o | output | 1 | Interrupt accepted: flush and jump |
| vec_pc_o | output | 11 | Vector address |
| in_isr_o | output | 1 | Handler active or return in progress |
| restore_o | output | 1 | Restore strobe |
| rst_pc_o | output | 11 | Restored program counter |
| rst_w_o | output | 8 | Restored working register |
| rst_status_o | output | 8 | Restored status byte with live TO/PD |
| rst_fsr_o | output | 8 | Restored file select register |
| rtcc_wr_o | output | 1 | Real-time counter write strobe |
| rtcc_wdata_o | output | 8 | Real-time counter write value |

## Verification
The assertions check on every cycle that a take is always followed by the handler flag, that a request stays pending while the handler runs, and that a restore only follows a cycle inside the handler. They also check that the handler flag drops after a restore and that the shadow copy does not change inside a handler. Only the bench scenarios can show the values themselves. These are the restored context and the status merge with live TO/PD, the counter sum that wraps past 255, the two return latencies, and the requests and opcodes that are ignored. The bench's reference model compares these every cycle against random live inputs.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  localparam int unsigned INSTR_W = 12;

  localparam logic [INSTR_W-1:0] OP_RET_PLAIN = 12'h00E;
  localparam logic [INSTR_W-1:0] OP_RET_ADDW  = 12'h00F;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_ISR = 2'd1,
    ST_RET = 2'd2
  } ctx_state_e;

  typedef struct packed {
    logic any_ret;
    logic add_w;
  } ret_dec_t;

endpackage

// File: rtl/irq_ctx_decode.sv
module irq_ctx_decode
  import irq_ctx_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output ret_dec_t           dec_o
);

  logic hit_plain;
  logic hit_addw;

  always_comb begin
    hit_plain     = valid_i && (instr_i == OP_RET_PLAIN);
    hit_addw      = valid_i && (instr_i == OP_RET_ADDW);
    dec_o.any_ret = hit_plain || hit_addw;
    dec_o.add_w   = hit_addw;
  end

endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int unsigned RET_CYC       = 2,
  parameter int unsigned RET_CYC_TURBO = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     irq_req_i,
  input  logic     turbo_i,
  input  ret_dec_t dec_i,
  output logic     take_o,
  output logic     ret_start_o,
  output logic     restore_o,
  output logic     rtcc_wr_o,
  output logic     in_isr_o
);

  localparam int unsigned CNT_W = $clog2(RET_CYC_TURBO + 1);
  localparam logic [CNT_W-1:0] LIM_NORM  = CNT_W'(RET_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_TURBO = CNT_W'(RET_CYC_TURBO - 1);

  ctx_state_e       state_q, state_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             addw_q, addw_d;
  logic             ret_en;

  always_comb begin
    take_o      = pend_q && (state_q == ST_RUN);
    ret_start_o = (state_q == ST_ISR) && dec_i.any_ret;
    restore_o   = (state_q == ST_RET) && (cnt_q == lim_q);
    rtcc_wr_o   = restore_o && addw_q;
    in_isr_o    = (state_q != ST_RUN);

    pend_d  = (pend_q && !take_o) || irq_req_i;
    state_d = state_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    addw_d  = addw_q;
    ret_en  = 1'b0;

    unique case (state_q)
      ST_RUN: if (take_o) state_d = ST_ISR;
      ST_ISR: if (ret_start_o) begin
        state_d = ST_RET;
        ret_en  = 1'b1;
        cnt_d   = CNT_W'(1);
        lim_d   = turbo_i ? LIM_TURBO : LIM_NORM;
        addw_d  = dec_i.add_w;
      end
      ST_RET: begin
        if (restore_o) state_d = ST_RUN;
        else begin
          ret_en = 1'b1;
          cnt_d  = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      addw_q <= 1'b0;
    end else if (ret_en) begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      addw_q <= addw_d;
    end
  end

  AST_TAKE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> in_isr_o); // R2
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && in_isr_o) |=> pend_q); // R3
  AST_RESTORE_AFTER_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> $past(in_isr_o)); // R4
  AST_NO_RET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_isr_o |=> !restore_o); // R8
  AST_RESTORE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> !in_isr_o); // R9

endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
  parameter int unsigned PC_W   = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TO_BIT = 4,
  parameter int unsigned PD_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ctx_i,
  input  logic              cap_w_i,
  input  logic              in_isr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] fsr_i,
  input  logic [DATA_W-1:0] rtcc_i,
  output logic [PC_W-1:0]   rst_pc_o,
  output logic [DATA_W-1:0] rst_w_o,
  output logic [DATA_W-1:0] rst_status_o,
  output logic [DATA_W-1:0] rst_fsr_o,
  output logic [DATA_W-1:0] rtcc_wdata_o
);

  logic [PC_W-1:0]   sh_pc_q;
  logic [DATA_W-1:0] sh_w_q;
  logic [DATA_W-1:0] sh_fsr_q;
  logic [DATA_W-1:0] addw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pc_q  <= '0;
      sh_w_q   <= '0;
      sh_fsr_q <= '0;
    end else if (cap_ctx_i) begin
      sh_pc_q  <= pc_i;
      sh_w_q   <= w_i;
      sh_fsr_q <= fsr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addw_q <= '0;
    else if (cap_w_i) addw_q <= w_i;
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (b == TO_BIT || b == PD_BIT) begin : g_live
      assign rst_status_o[b] = status_i[b];
    end else begin : g_kept
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else if (cap_ctx_i) bit_q <= status_i[b];
      end
      assign rst_status_o[b] = bit_q;
    end
  end

  always_comb begin
    rst_pc_o     = sh_pc_q;
    rst_w_o      = sh_w_q;
    rst_fsr_o    = sh_fsr_q;
    rtcc_wdata_o = rtcc_i + addw_q;
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_isr_i && !cap_ctx_i) |=> ($stable(sh_pc_q) && $stable(sh_w_q) && $stable(sh_fsr_q))); // R5

endmodule

// File: rtl/irq_ctx_unit.sv
module irq_ctx_unit
  import irq_ctx_pkg::*;
#(
  parameter int unsigned PC_W          = 11,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned VEC_ADDR      = 0,
  parameter int unsigned RET_CYC       = 2,
  parameter int unsigned RET_CYC_TURBO = 3,
  parameter int unsigned TO_BIT        = 4,
  parameter int unsigned PD_BIT        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic              turbo_i,
  input  logic              instr_valid_i,
  input  logic [11:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] fsr_i,
  input  logic [DATA_W-1:0] rtcc_i,
  output logic              take_o,
  output logic [PC_W-1:0]   vec_pc_o,
  output logic              in_isr_o,
  output logic              restore_o,
  output logic [PC_W-1:0]   rst_pc_o,
  output logic [DATA_W-1:0] rst_w_o,
  output logic [DATA_W-1:0] rst_status_o,
  output logic [DATA_W-1:0] rst_fsr_o,
  output logic              rtcc_wr_o,
  output logic [DATA_W-1:0] rtcc_wdata_o
);

  ret_dec_t dec;
  logic     ret_start;

  assign vec_pc_o = PC_W'(VEC_ADDR);

  irq_ctx_decode u_decode (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  irq_ctx_ctrl #(
    .RET_CYC       (RET_CYC),
    .RET_CYC_TURBO (RET_CYC_TURBO)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req_i   (irq_req_i),
    .turbo_i     (turbo_i),
    .dec_i       (dec),
    .take_o      (take_o),
    .ret_start_o (ret_start),
    .restore_o   (restore_o),
    .rtcc_wr_o   (rtcc_wr_o),
    .in_isr_o    (in_isr_o)
  );

  irq_ctx_shadow #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .TO_BIT (TO_BIT),
    .PD_BIT (PD_BIT)
  ) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_ctx_i    (take_o),
    .cap_w_i      (ret_start),
    .in_isr_i     (in_isr_o),
    .pc_i         (pc_i),
    .w_i          (w_i),
    .status_i     (status_i),
    .fsr_i        (fsr_i),
    .rtcc_i       (rtcc_i),
    .rst_pc_o     (rst_pc_o),
    .rst_w_o      (rst_w_o),
    .rst_status_o (rst_status_o),
    .rst_fsr_o    (rst_fsr_o),
    .rtcc_wdata_o (rtcc_wdata_o)
  );

endmodule

// File: tb/irq_ctx_unit_bench.sv
`timescale 1ns/1ps
module irq_ctx_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, turbo = 1'b0, ivalid = 1'b0;
  logic [11:0] instr = 12'h000;
  logic [10:0] pc = '0;
  logic [7:0]  w = '0, st = '0, fsr = '0, rtcc = '0;

  logic        take, in_isr, restore, rtcc_wr;
  logic [10:0] vec_pc, r_pc;
  logic [7:0]  r_w, r_st, r_fsr, rtcc_wdata;

  int checks = 0, fails = 0, cyc = 0;

  // reference model state
  int m_state = 0, m_left = 0;
  bit m_pend = 0, m_addw = 0;
  int m_pc = 0, m_w = 0, m_st = 0, m_fsr = 0, m_retw = 0;

  always #10 clk = ~clk;

  irq_ctx_unit u_irq_ctx_unit (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .turbo_i(turbo),
    .instr_valid_i(ivalid), .instr_i(instr), .pc_i(pc), .w_i(w),
    .status_i(st), .fsr_i(fsr), .rtcc_i(rtcc), .take_o(take),
    .vec_pc_o(vec_pc), .in_isr_o(in_isr), .restore_o(restore),
    .rst_pc_o(r_pc), .rst_w_o(r_w), .rst_status_o(r_st),
    .rst_fsr_o(r_fsr), .rtcc_wr_o(rtcc_wr), .rtcc_wdata_o(rtcc_wdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", tag, cyc, act, exp);
    end
  endtask

  // model update at the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pend = 0; m_left = 0; m_addw = 0;
    end else begin
      bit tk;
      tk = m_pend && (m_state == 0);
      cyc++;
      if (m_state == 0 && tk) begin
        m_pc = pc; m_w = w; m_st = st; m_fsr = fsr; m_state = 1;
      end else if (m_state == 1 && ivalid && (instr == 12'h00E || instr == 12'h00F)) begin
        m_state = 2; m_addw = (instr == 12'h00F); m_retw = w; m_left = turbo ? 1 : 0;
      end else if (m_state == 2) begin
        if (m_left == 0) m_state = 0; else m_left--;
      end
      m_pend = (m_pend && !tk) || irq_req;
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    bit e_take, e_rest, e_wr;
    int e_st, e_sum;
    e_take = m_pend && (m_state == 0);
    e_rest = (m_state == 2) && (m_left == 0);
    e_wr   = e_rest && m_addw;
    e_st   = (m_st & 8'hE7) | (st & 8'h18);
    e_sum  = (rtcc + m_retw) % 256;
    if (!rst_n) begin
      chk(!take && !restore && !rtcc_wr && !in_isr, "R1 reset outputs",
          {take, restore, rtcc_wr, in_isr}, 0);
    end else begin
      chk(take == e_take, "R2/R3 take", take, e_take);
      chk(restore == e_rest, "R4/R8 restore", restore, e_rest);
      chk(in_isr == (m_state != 0), "R9 in_isr", in_isr, m_state != 0);
      chk(rtcc_wr == e_wr, "R7 rtcc_wr", rtcc_wr, e_wr);
      if (e_take) chk(vec_pc == 0, "R2 vector", vec_pc, 0);
      if (e_rest) begin
        chk(r_pc == m_pc && r_w == m_w && r_fsr == m_fsr, "R5 pc/w/fsr",
            {r_pc, r_w, r_fsr}, {m_pc[10:0], m_w[7:0], m_fsr[7:0]});
        chk(r_st == e_st, "R6 status", r_st, e_st);
      end
      if (e_wr) chk(rtcc_wdata == e_sum, "R7 rtcc sum", rtcc_wdata, e_sum);
    end
  end

  task automatic step(input bit irq, input bit v, input logic [11:0] op, input bit tb);
    @(posedge clk); #2;
    irq_req = irq; ivalid = v; instr = op; turbo = tb;
    pc = 11'($urandom); w = 8'($urandom); st = 8'($urandom);
    fsr = 8'($urandom); rtcc = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 12'h000, 0);
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    @(posedge clk); #2 rst_n = 1'b1;
    idle(3);
    // R8: return outside handler ignored
    step(0, 1, 12'h00E, 0); step(0, 1, 12'h00F, 1); idle(2);
    // R2: request, take, then sleep / watchdog-clear opcodes inside handler (R8)
    step(1, 0, 12'h000, 0); idle(3);
    step(0, 1, 12'h003, 0); step(0, 1, 12'h004, 0); step(0, 0, 12'h00E, 0);
    // R4/R5/R6: plain return, normal latency
    step(0, 1, 12'h00E, 0); idle(3);
    // R3: request during handler stays pending until restore
    step(1, 0, 12'h000, 0); idle(2);
    step(1, 0, 12'h000, 0); idle(2);
    // R7: add-W return, turbo latency, wrapping sum; R8 second return ignored
    step(0, 1, 12'h00F, 1); w = 8'hF0; rtcc = 8'h20;
    step(0, 1, 12'h00F, 0); step(0, 1, 12'h00E, 0); idle(4);
    // handler from the retained request returns with add-W, normal latency
    step(0, 1, 12'h00F, 0); idle(4);
    // random soak
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [11:0] op;
      r = $urandom_range(0, 9);
      op = (r < 2) ? 12'h00E : (r < 4) ? 12'h00F : (r < 5) ? 12'h003 : 12'($urandom);
      step($urandom_range(0, 9) == 0, $urandom_range(0, 1), op, $urandom_range(0, 1));
    end
    idle(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule